// File: doc/BRIEF.md
# JTAG Scan Tunnel Controller

A host debug probe can reach the test access port of a soft processor buried in the fabric, even though the device's own TAP keeps its IR scans to itself. Only two things from the host TAP reach the fabric: the instruction value it currently holds and the bits of each DR scan. The hub watches the held instruction. When the instruction equals the code of one of its controller instances, that instance reads the host DR scan as a tunnel packet. The packet tells it to run one IR scan or one DR scan on its own target TAP. The target's TDO bits flow back to the host inside the same host DR scan, at a fixed offset.

A packet starts with one type bit, 1 for an IR scan and 0 for a DR scan. Next come seven bits that hold the scan length N minus 1, least significant bit first. Then come N payload bits and one trailing bit. Host steps are numbered from 0, where step s is the s-th host TCK rising edge with Shift-DR active, counted since the last Update-DR or Test-Logic-Reset. The target sees the TMS, TDI and TCK values in step with these host steps. The hub holds up to 16 instances, and instance i answers to the code 0x55+i. Every register is clocked by the host TCK. A host DR scan carrying an N-bit packet must last at least N+11 steps.

Top module: `jtun_hub`

## Requirements
- R1: Instance i decodes a host DR scan only while `host_ir` equals 0x55+i. A scan under one code never clocks, drives or alters any other instance's target.
- R2: Packet step 0 gives the type (1 = IR scan, 0 = DR scan). Steps 1..7 give N-1, least significant bit first. Steps 8..8+N-1 give the payload, and the target receives it on TDI in that same order, first bit first.
- R3: From Run-Test/Idle, the target TMS follows this order: Select-DR, then Select-IR for an IR scan only, then Capture, then Shift for N bits with TMS high on the last one, then Exit1, then Update. The target is back in Run-Test/Idle before the scan ends, and the requested scan type and length are recorded.
- R4: The target TDO bit k (k = 0..N-1, the first bit shifted out is k = 0) appears on `host_tdo` in the interval after host step 8+k+RET_DELAY.
- R5: The trailing bit at step 8+N, and every bit after it, has no effect on the target scan.
- R6: When no code matches, `host_tdo` is 0. A non-selected target gets no TCK pulses, and its TMS and TDI stay 0.
- R7: A pulse on `host_update_dr` or `host_tlr` returns the decoder to step 0. A packet cut short inside its header then leaves the next packet correctly framed.
- R8: `tgt_rst[i]` equals `host_trst_n` when bit i of RST_HIGH_MASK is 0, and equals its inverse when the bit is 1.
- R9: After synchronous reset, `host_tdo`, `tgt_tms` and `tgt_tdi` are 0.
- R10: The lengths N = 1 and N = 128 (length field 0 and 127) work like any other length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Host test clock; clocks every register |
| rst | input | 1 | Synchronous active-high reset |
| host_ir | input | 8 | Instruction value held by the host TAP |
| host_shift_dr | input | 1 | Host TAP is in Shift-DR |
| host_update_dr | input | 1 | Host TAP is in Update-DR |
| host_tlr | input | 1 | Host TAP is in Test-Logic-Reset |
| host_tdi | input | 1 | Host serial data in |
| host_trst_n | input | 1 | Host active-low test reset |
| host_tdo | output | 1 | Serial data back to the host |
| tgt_tck | output | NUM_TARGETS | Test clock per target, pulsed on selected steps |
| tgt_tms | output | NUM_TARGETS | Test mode select per target |
| tgt_tdi | output | NUM_TARGETS | Serial data per target |
| tgt_tdo | input | NUM_TARGETS | Serial data from each target |
| tgt_rst | output | NUM_TARGETS | Target test reset, polarity chosen per target |

## Verification
The bench builds the hub with NUM_TARGETS = 3, RET_DELAY = 2 and RST_HIGH_MASK = 3'b010. Three instances are enough to show that scans under one code leave the two neighbours untouched. The mixed mask exercises both reset polarities at once. A code outside the populated range (0x60) reaches the no-match path. Each target is a behavioural TAP model that records its scans and shifts out its own capture pattern, so both the TMS order and the returned-bit offset are checked against an independent state machine.

// File: rtl/jtun_pkg.sv
package jtun_pkg;

    localparam int          MAX_TGTS  = 16;
    localparam logic [7:0]  CODE_BASE = 8'h55;
    localparam int          LEN_W     = 7;
    localparam int          HDR_BITS  = LEN_W + 1;
    localparam int          POS_W     = 9;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef logic [POS_W-1:0] pos_t;

    // decoder progress through one packet
    typedef struct packed {
        pos_t             pos;
        logic             ir_sel;
        logic [LEN_W-1:0] len;
    } hdr_t;

    function automatic logic [7:0] code_of(input int idx);
        return CODE_BASE + 8'(idx);
    endfunction

    // step index of the last payload bit (len + 8)
    function automatic pos_t last_pay(input hdr_t h);
        return pos_t'(h.len) + pos_t'(HDR_BITS);
    endfunction

    function automatic logic in_shift(input hdr_t h);
        return (h.pos >= pos_t'(HDR_BITS)) && (h.pos <= last_pay(h));
    endfunction

    function automatic logic in_capture(input hdr_t h);
        return (h.pos >= pos_t'(HDR_BITS + 1)) && (h.pos <= last_pay(h) + pos_t'(1));
    endfunction

    // TMS the target sees on the tick after the step at h.pos
    function automatic logic next_tms(input hdr_t h);
        if (h.pos == pos_t'(4))        return h.ir_sel;
        if (h.pos == pos_t'(5))        return 1'b1;
        if (in_shift(h))               return h.pos == last_pay(h);
        if (h.pos == last_pay(h) + pos_t'(1)) return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/jtun_match.sv
module jtun_match #(
    parameter logic [7:0] CODE = 8'h55
) (
    input  logic [7:0] host_ir,
    output logic       hit
);
    assign hit = (host_ir == CODE);
endmodule

// File: rtl/jtun_retline.sv
module jtun_retline #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic adv,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] line_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (clr)      line_q <= '0;
                else if (adv) line_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (clr)      line_q <= '0;
                else if (adv) line_q <= {line_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/jtun_ctrl.sv
module jtun_ctrl
    import jtun_pkg::*;
#(
    parameter logic [7:0] CODE      = CODE_BASE,
    parameter bit         RST_HIGH  = 1'b0,
    parameter int         RET_DELAY = 2
) (
    input  logic       tck,
    input  logic       rst,
    input  logic [7:0] host_ir,
    input  logic       host_shift_dr,
    input  logic       host_update_dr,
    input  logic       host_tlr,
    input  logic       host_tdi,
    input  logic       host_trst_n,
    input  logic       tgt_tdo,
    output logic       sel,
    output logic       ret_bit,
    output logic       tgt_tck,
    output logic       tgt_tms,
    output logic       tgt_tdi,
    output logic       tgt_rst
);
    hdr_t st;
    logic step, abort, clr;
    logic tms_q, tdi_q, en_q, cap_bit, line_out;

    jtun_match #(.CODE(CODE)) u_match (.host_ir(host_ir), .hit(sel));

    assign step  = host_shift_dr & sel;
    assign abort = host_update_dr | host_tlr;
    assign clr   = rst | abort;

    always_ff @(posedge tck) begin
        if (clr) begin
            st    <= '0;
            tms_q <= 1'b0;
            tdi_q <= 1'b0;
        end else if (step) begin
            if (st.pos == '0)
                st.ir_sel <= host_tdi;
            else if (st.pos < pos_t'(HDR_BITS))
                st.len[3'(st.pos - pos_t'(1))] <= host_tdi;
            tms_q <= next_tms(st);
            tdi_q <= in_shift(st) ? host_tdi : 1'b0;
            if (st.pos != POS_MAX)
                st.pos <= st.pos + pos_t'(1);
        end
    end

    // target clock enable, settled while tck is low
    always_ff @(negedge tck) begin
        en_q <= ~rst & step & ~abort;
    end

    assign cap_bit = in_capture(st) ? tgt_tdo : 1'b0;

    jtun_retline #(.DEPTH(RET_DELAY)) u_ret (
        .clk (tck),
        .clr (clr),
        .adv (step),
        .din (cap_bit),
        .dout(line_out)
    );

    assign ret_bit = sel & line_out;
    assign tgt_tck = tck & en_q;
    assign tgt_tms = sel & tms_q;
    assign tgt_tdi = sel & tdi_q;
    assign tgt_rst = RST_HIGH ? ~host_trst_n : host_trst_n;
endmodule

// File: rtl/jtun_hub.sv
module jtun_hub
    import jtun_pkg::*;
#(
    parameter int          NUM_TARGETS   = 2,
    parameter int          RET_DELAY     = 2,
    parameter logic [15:0] RST_HIGH_MASK = 16'h0000
) (
    input  logic                   tck,
    input  logic                   rst,
    input  logic [7:0]             host_ir,
    input  logic                   host_shift_dr,
    input  logic                   host_update_dr,
    input  logic                   host_tlr,
    input  logic                   host_tdi,
    input  logic                   host_trst_n,
    output logic                   host_tdo,
    output logic [NUM_TARGETS-1:0] tgt_tck,
    output logic [NUM_TARGETS-1:0] tgt_tms,
    output logic [NUM_TARGETS-1:0] tgt_tdi,
    input  logic [NUM_TARGETS-1:0] tgt_tdo,
    output logic [NUM_TARGETS-1:0] tgt_rst
);
    logic [NUM_TARGETS-1:0] sel_v, ret_v;

    generate
        for (genvar i = 0; i < NUM_TARGETS; i++) begin : g_inst
            jtun_ctrl #(
                .CODE     (code_of(i)),
                .RST_HIGH (RST_HIGH_MASK[i]),
                .RET_DELAY(RET_DELAY)
            ) u_ctrl (
                .tck           (tck),
                .rst           (rst),
                .host_ir       (host_ir),
                .host_shift_dr (host_shift_dr),
                .host_update_dr(host_update_dr),
                .host_tlr      (host_tlr),
                .host_tdi      (host_tdi),
                .host_trst_n   (host_trst_n),
                .tgt_tdo       (tgt_tdo[i]),
                .sel           (sel_v[i]),
                .ret_bit       (ret_v[i]),
                .tgt_tck       (tgt_tck[i]),
                .tgt_tms       (tgt_tms[i]),
                .tgt_tdi       (tgt_tdi[i]),
                .tgt_rst       (tgt_rst[i])
            );
        end
    endgenerate

    // codes are distinct, so at most one term is live
    always_comb begin
        host_tdo = 1'b0;
        for (int i = 0; i < NUM_TARGETS; i++)
            host_tdo = host_tdo | (sel_v[i] & ret_v[i]);
    end
endmodule

// File: rtl/jtun_hub_chk.sv
module jtun_hub_chk
    import jtun_pkg::*;
#(
    parameter int          NUM_TARGETS   = 2,
    parameter int          RET_DELAY     = 2,
    parameter logic [15:0] RST_HIGH_MASK = 16'h0000
) (
    input logic                   tck,
    input logic                   rst,
    input logic [7:0]             host_ir,
    input logic                   host_shift_dr,
    input logic                   host_update_dr,
    input logic                   host_tlr,
    input logic                   host_tdi,
    input logic                   host_trst_n,
    input logic                   host_tdo,
    input logic [NUM_TARGETS-1:0] tgt_tck,
    input logic [NUM_TARGETS-1:0] tgt_tms,
    input logic [NUM_TARGETS-1:0] tgt_tdi,
    input logic [NUM_TARGETS-1:0] tgt_tdo,
    input logic [NUM_TARGETS-1:0] tgt_rst
);
    logic [NUM_TARGETS-1:0] want;

    always_comb begin
        for (int i = 0; i < NUM_TARGETS; i++)
            want[i] = (host_ir == code_of(i));
    end

    assert_quiet_tdo_R6: assert property (@(posedge tck) disable iff (rst)
        (want == '0) |-> (host_tdo == 1'b0));

    assert_unsel_tms_R6: assert property (@(posedge tck) disable iff (rst)
        (tgt_tms & ~want) == '0);

    assert_unsel_tdi_R6: assert property (@(posedge tck) disable iff (rst)
        (tgt_tdi & ~want) == '0);

    assert_single_tms_R1: assert property (@(posedge tck) disable iff (rst)
        $onehot0(tgt_tms));

    assert_abort_idle_R7: assert property (@(posedge tck) disable iff (rst)
        host_update_dr |=> (tgt_tms == '0) && (tgt_tdi == '0));

    assert_rst_polarity_R8: assert property (@(posedge tck) disable iff (rst)
        tgt_rst == ({NUM_TARGETS{host_trst_n}} ^ RST_HIGH_MASK[NUM_TARGETS-1:0]));

    assert_reset_clean_R9: assert property (@(posedge tck)
        rst |=> (host_tdo == 1'b0) && (tgt_tms == '0) && (tgt_tdi == '0));
endmodule

bind jtun_hub jtun_hub_chk #(
    .NUM_TARGETS  (NUM_TARGETS),
    .RET_DELAY    (RET_DELAY),
    .RST_HIGH_MASK(RST_HIGH_MASK)
) u_chk (.*);

// File: tb/jtun_hub_test.sv
module jtun_tap_model #(
    parameter logic [127:0] CAP_IR = '0,
    parameter logic [127:0] CAP_DR = '0
) (
    input  logic         tck,
    input  logic         tms,
    input  logic         tdi,
    output logic         tdo,
    output int           state,
    output int           last_len,
    output logic         last_ir,
    output logic [127:0] last_data,
    output int           ticks
);
    int           st_r = 0;
    int           cnt = 0;
    int           len_r = 0;
    int           tk_r = 0;
    logic         ir_r = 1'b0;
    logic         tdo_r = 1'b0;
    logic [127:0] rec = '0;
    logic [127:0] data_r = '0;

    // 0 idle, 1 sel-dr, 2 cap-dr, 3 sh-dr, 4 ex1-dr, 5 upd-dr,
    // 7 sel-ir, 8 cap-ir, 9 sh-ir, 10 ex1-ir, 11 upd-ir, 15 bad
    always @(posedge tck) begin
        tk_r = tk_r + 1;
        case (st_r)
            0:  st_r = tms ? 1 : 0;
            1:  st_r = tms ? 7 : 2;
            2:  begin cnt = 0; rec = '0; st_r = tms ? 4 : 3; end
            3:  begin if (cnt < 128) rec[7'(cnt)] = tdi; cnt = cnt + 1; st_r = tms ? 4 : 3; end
            4:  st_r = tms ? 5 : 15;
            5:  begin ir_r = 1'b0; len_r = cnt; data_r = rec; st_r = tms ? 1 : 0; end
            7:  st_r = tms ? 15 : 8;
            8:  begin cnt = 0; rec = '0; st_r = tms ? 10 : 9; end
            9:  begin if (cnt < 128) rec[7'(cnt)] = tdi; cnt = cnt + 1; st_r = tms ? 10 : 9; end
            10: st_r = tms ? 11 : 15;
            11: begin ir_r = 1'b1; len_r = cnt; data_r = rec; st_r = tms ? 1 : 0; end
            default: st_r = 15;
        endcase
    end

    always @(negedge tck) begin
        if (st_r == 3 && cnt < 128)      tdo_r <= CAP_DR[7'(cnt)];
        else if (st_r == 9 && cnt < 128) tdo_r <= CAP_IR[7'(cnt)];
        else                             tdo_r <= 1'b0;
    end

    assign tdo       = tdo_r;
    assign state     = st_r;
    assign last_len  = len_r;
    assign last_ir   = ir_r;
    assign last_data = data_r;
    assign ticks     = tk_r;
endmodule

module jtun_hub_test;
    localparam int          NT   = 3;
    localparam int          RD   = 2;
    localparam logic [15:0] MASK = 16'h0002;

    typedef struct {
        logic [127:0] exp;
        int           n;
        string        tag;
    } sb_item_t;

    logic          tck = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    host_ir = 8'h00;
    logic          host_shift_dr = 1'b0;
    logic          host_update_dr = 1'b0;
    logic          host_tlr = 1'b0;
    logic          host_tdi = 1'b0;
    logic          host_trst_n = 1'b1;
    logic          host_tdo;
    logic [NT-1:0] tgt_tck, tgt_tms, tgt_tdi, tgt_tdo, tgt_rst;

    int           m_state [NT];
    int           m_len   [NT];
    logic         m_ir    [NT];
    logic [127:0] m_data  [NT];
    int           m_ticks [NT];

    int checks = 0;
    int errors = 0;
    sb_item_t sb_q[$];
    logic [127:0] got;
    event done_ev;

    always #4 tck = ~tck;

    function automatic logic [127:0] cap_val(input int i, input bit ir);
        logic [127:0] v;
        for (int w = 0; w < 4; w++)
            v[w*32 +: 32] = (32'h9E37_79B9 * 32'(i*8 + w + 1 + (ir ? 4 : 0))) ^ 32'h5A5A_0F0F;
        return v;
    endfunction

    function automatic logic [127:0] mask_of(input int n);
        logic [127:0] m;
        m = '0;
        for (int b = 0; b < n; b++) m[b] = 1'b1;
        return m;
    endfunction

    jtun_hub #(.NUM_TARGETS(NT), .RET_DELAY(RD), .RST_HIGH_MASK(MASK)) uut (
        .tck(tck), .rst(rst), .host_ir(host_ir), .host_shift_dr(host_shift_dr),
        .host_update_dr(host_update_dr), .host_tlr(host_tlr), .host_tdi(host_tdi),
        .host_trst_n(host_trst_n), .host_tdo(host_tdo), .tgt_tck(tgt_tck),
        .tgt_tms(tgt_tms), .tgt_tdi(tgt_tdi), .tgt_tdo(tgt_tdo), .tgt_rst(tgt_rst)
    );

    generate
        for (genvar i = 0; i < NT; i++) begin : g_tgt
            jtun_tap_model #(.CAP_IR(cap_val(i, 1'b1)), .CAP_DR(cap_val(i, 1'b0))) u_m (
                .tck(tgt_tck[i]), .tms(tgt_tms[i]), .tdi(tgt_tdi[i]), .tdo(tgt_tdo[i]),
                .state(m_state[i]), .last_len(m_len[i]), .last_ir(m_ir[i]),
                .last_data(m_data[i]), .ticks(m_ticks[i])
            );
        end
    endgenerate

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic sh, input logic d);
        host_shift_dr = sh;
        host_tdi      = d;
        @(posedge tck);
        #2;
    endtask

    task automatic pulse_update();
        cyc(1'b0, 1'b0);
        host_update_dr = 1'b1;
        cyc(1'b0, 1'b0);
        host_update_dr = 1'b0;
        cyc(1'b0, 1'b0);
    endtask

    // one full tunnel packet; readback goes to the scoreboard
    task automatic send_pkt(input int tgt, input bit ir, input int n,
                            input logic [127:0] pay, input bit trail, input string tag);
        logic [6:0] len;
        sb_item_t   it;
        len     = 7'(n - 1);
        host_ir = jtun_pkg::code_of(tgt);
        cyc(1'b0, 1'b0);
        it.exp = cap_val(tgt, ir);
        it.n   = n;
        it.tag = tag;
        sb_q.push_back(it);
        got = '0;
        for (int s = 0; s < n + 12; s++) begin
            logic b;
            int   k;
            if (s == 0)          b = ir;
            else if (s < 8)      b = len[s-1];
            else if (s < 8 + n)  b = pay[s-8];
            else if (s == 8 + n) b = trail;
            else                 b = 1'b0;
            cyc(1'b1, b);
            k = s - 8 - RD;
            if (k >= 0 && k < n) got[k] = host_tdo;
        end
        pulse_update();
        ->done_ev;
        #1;
        host_ir = 8'h00;
    endtask

    task automatic check_scan(input int tgt, input bit ir, input int n,
                              input logic [127:0] pay, input string req);
        logic [127:0] m;
        m = mask_of(n);
        check(m_state[tgt] == 0, req, "target back in idle", 128'(m_state[tgt]), 128'd0);
        check(m_ir[tgt] == ir, req, "scan type", 128'(m_ir[tgt]), 128'(ir));
        check(m_len[tgt] == n, req, "scan length", 128'(m_len[tgt]), 128'(n));
        check((m_data[tgt] & m) == (pay & m), req, "payload bits",
              m_data[tgt] & m, pay & m);
    endtask

    // scoreboard monitor: compares returned target bits
    initial begin
        forever begin
            @(done_ev);
            if (sb_q.size() == 0) begin
                check(1'b0, "R4", "unexpected readback", got, '0);
            end else begin
                sb_item_t it;
                logic [127:0] m;
                it = sb_q.pop_front();
                m  = mask_of(it.n);
                check((got & m) == (it.exp & m), "R4", it.tag, got & m, it.exp & m);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0 [NT];
        logic [127:0] p;

        repeat (3) cyc(1'b0, 1'b0);
        rst = 1'b0;
        cyc(1'b0, 1'b0);

        // R9 reset state
        check(host_tdo == 1'b0, "R9", "host_tdo after reset", 128'(host_tdo), 128'd0);
        check(tgt_tms == '0 && tgt_tdi == '0, "R9", "target tms/tdi after reset",
              128'({tgt_tms, tgt_tdi}), 128'd0);

        // R8 reset polarity per target
        host_trst_n = 1'b0;
        cyc(1'b0, 1'b0);
        check(tgt_rst == 3'b010, "R8", "tgt_rst with trst_n low", 128'(tgt_rst), 128'(3'b010));
        host_trst_n = 1'b1;
        cyc(1'b0, 1'b0);
        check(tgt_rst == 3'b101, "R8", "tgt_rst with trst_n high", 128'(tgt_rst), 128'(3'b101));

        // R1 R2 R3 R4 DR scan on target 0, neighbours untouched
        for (int i = 0; i < NT; i++) t0[i] = m_ticks[i];
        send_pkt(0, 1'b0, 8, 128'hB6, 1'b0, "R4 dr8 tgt0");
        check_scan(0, 1'b0, 8, 128'hB6, "R2");
        check(m_ticks[1] == t0[1] && m_ticks[2] == t0[2], "R1", "neighbour ticks",
              128'({m_ticks[1], m_ticks[2]}), 128'({t0[1], t0[2]}));
        check(m_ticks[0] == t0[0] + 20, "R3", "selected target tick count",
              128'(m_ticks[0]), 128'(t0[0] + 20));

        // R3 IR scan on target 1
        send_pkt(1, 1'b1, 5, 128'h13, 1'b0, "R4 ir5 tgt1");
        check_scan(1, 1'b1, 5, 128'h13, "R3");

        // R10 shortest and longest lengths
        send_pkt(2, 1'b0, 1, 128'h1, 1'b0, "R10 dr1 tgt2");
        check_scan(2, 1'b0, 1, 128'h1, "R10");
        p = {32'hC0DE_1234, 32'h0BAD_F00D, 32'h7654_3210, 32'hFEDC_BA98};
        send_pkt(0, 1'b0, 128, p, 1'b1, "R10 dr128 tgt0");
        check_scan(0, 1'b0, 128, p, "R10");
        send_pkt(1, 1'b1, 128, ~p, 1'b0, "R10 ir128 tgt1");
        check_scan(1, 1'b1, 128, ~p, "R10");

        // R5 trailing bit set makes no difference
        send_pkt(0, 1'b0, 8, 128'hB6, 1'b1, "R5 dr8 trail1");
        check_scan(0, 1'b0, 8, 128'hB6, "R5");

        // R6 unpopulated code: no ticks, host_tdo held low
        for (int i = 0; i < NT; i++) t0[i] = m_ticks[i];
        host_ir = 8'h60;
        begin
            bit quiet;
            quiet = 1'b1;
            for (int s = 0; s < 24; s++) begin
                cyc(1'b1, s[0]);
                if (host_tdo !== 1'b0 || tgt_tms != '0 || tgt_tdi != '0) quiet = 1'b0;
            end
            check(quiet, "R6", "outputs quiet under unmatched code", 128'(quiet), 128'd1);
        end
        pulse_update();
        check(m_ticks[0] == t0[0] && m_ticks[1] == t0[1] && m_ticks[2] == t0[2], "R6",
              "no target ticks under unmatched code",
              128'({m_ticks[0], m_ticks[1], m_ticks[2]}), 128'({t0[0], t0[1], t0[2]}));
        host_ir = 8'h00;

        // R7 header cut by update-dr, then a clean packet
        host_ir = jtun_pkg::code_of(1);
        for (int s = 0; s < 5; s++) cyc(1'b1, 1'b1);
        pulse_update();
        check(m_state[1] == 0, "R7", "target idle after cut header", 128'(m_state[1]), 128'd0);
        send_pkt(1, 1'b0, 6, 128'h2D, 1'b0, "R7 after update cut");
        check_scan(1, 1'b0, 6, 128'h2D, "R7");

        // R7 header cut by test-logic-reset
        host_ir = jtun_pkg::code_of(2);
        for (int s = 0; s < 3; s++) cyc(1'b1, 1'b1);
        host_shift_dr = 1'b0;
        host_tlr = 1'b1;
        cyc(1'b0, 1'b0);
        host_tlr = 1'b0;
        cyc(1'b0, 1'b0);
        send_pkt(2, 1'b1, 3, 128'h5, 1'b0, "R7 after tlr cut");
        check_scan(2, 1'b1, 3, 128'h5, "R7");

        repeat (4) cyc(1'b0, 1'b0);
        check(sb_q.size() == 0, "R4", "scoreboard drained", 128'(sb_q.size()), 128'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule